// File: doc/BRIEF.md
# Multi-Mode PRG Bank Mapper

This block sits between a CPU address bus and a program ROM. It converts a CPU read address in the upper 40 KiB of the map ($6000-$FFFF) into a physical ROM address. Four 7-bit bank registers and a mode register are written over the CPU bus. The mode register picks one of four banking granularities: one of them bit-reverses the bank number. It also decides whether the top slot is fixed to the last bank or steered by the fourth bank register. A third bit decides whether the $6000-$7FFF window shows a ROM bank or work RAM.

The block produces only the translated address and two enables: ROM and WRAM. The ROM, the RAM and the open-bus data are outside it. A parameter sets the size of the inner bank space. Only the low bank bits survive, and an outer-bank input supplies the address bits above them. The mapping is combinational from the registers, so the cycle after a register write already uses the new layout.

Top module: `prg_bank_mapper`

## Requirements
- R1: A write with address bits 15:12 equal to 8 and bit 11 clear loads bank register (address bits 1:0), 0 to 3. Bits 10:2 are don't-care, and only data bits 6:0 are kept.
- R2: A write with address bit 11 set changes neither the bank registers nor the mode register.
- R3: The mode register is written at address bits 15:12 = $D, bit 11 clear, bits 1:0 = 0. Its fields are:
  - bits 1:0: banking mode, 0 = 32 KiB, 1 = 16 KiB, 2 = 8 KiB, 3 = 8 KiB reversed.
  - bit 2: top slot switchable.
  - bit 7: ROM in the $6000 window.
  Writes to other $Dxxx offsets leave it alone.
- R4: In 8 KiB mode, bank registers 0, 1, 2 and 3 map $8000, $A000, $C000 and $E000 respectively, in 8 KiB units.
- R5: In 16 KiB mode, register 1 maps $8000-$BFFF and the top slot maps $C000-$FFFF. The 8 KiB bank is the 16 KiB bank shifted left by one, ORed with address bit 13.
- R6: In 32 KiB mode, the top slot maps $8000-$FFFF. The 8 KiB bank is the 32 KiB bank shifted left by two, ORed with address bits 14:13.
- R7: When mode bit 2 is clear, the top slot holds the all-ones bank, which is the last bank of the outer bank. When bit 2 is set, register 3 drives it.
- R8: In mode 3, bank register values are bit-reversed across bits 6:0 before use.
- R9: In the window $6000-$7FFF, what appears depends on mode bit 7:
  - Set: the ROM is enabled with 8 KiB bank r3, (r3<<1)|1 or (r3<<2)|3 in 8, 16 or 32 KiB mode.
  - Clear: WRAM is enabled and the ROM is not.
- R10: The ROM address is {outer_bank, bank[INNER_W-1:0], cpu_rd_addr[12:0]}. INNER_W is log2(OUTER_KB/8), which is 6 by default.
- R11: After reset, all registers are zero: 32 KiB mode with the last bank fixed, and WRAM in the window.
- R12: A register write affects the mapping seen in the very next clock cycle.
- R13: Below $6000, neither enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_addr | input | 16 | CPU write address |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_rd_addr | input | 16 | CPU read address to translate |
| outer_bank | input | OUTER_W | Upper ROM address bits |
| prg_addr | output | OUTER_W+INNER_W+13 | Translated ROM address |
| rom_en | output | 1 | ROM selected |
| wram_en | output | 1 | WRAM selected |

## Verification
The assertions watch, on every cycle, the properties that hold whatever the registers contain:
- the two enables never assert together;
- nothing is enabled below $6000;
- the offset and outer bits pass through unchanged;
- a write with bit 11 set leaves the mapping unchanged.

Which bank lands in which slot for each mode, the fixed last bank, the bit reversal and the shift-and-fill of the window depend on register state. Only the bench's write-then-read scenarios can show those, by comparing against bank numbers worked out by hand.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int OUTER_KB = 512,
  parameter int OUTER_W = 2,
  localparam int INNER_W = $clog2(OUTER_KB / 8),
  localparam int AW = OUTER_W + INNER_W + 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr_en,
  input  logic [15:0]        cpu_wr_addr,
  input  logic [7:0]         cpu_wr_data,
  input  logic [15:0]        cpu_rd_addr,
  input  logic [OUTER_W-1:0] outer_bank,
  output logic [AW-1:0]      prg_addr,
  output logic               rom_en,
  output logic               wram_en
);

  logic [6:0] bank_q [4];
  logic [1:0] pmode_q;
  logic       top_sw_q;
  logic       win_rom_q;

  wire bank_wr = cpu_wr_en && cpu_wr_addr[15:12] == 4'h8 && !cpu_wr_addr[11];
  wire mode_wr = cpu_wr_en && cpu_wr_addr[15:12] == 4'hD && !cpu_wr_addr[11]
                 && cpu_wr_addr[1:0] == 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) bank_q[i] <= '0;
      pmode_q   <= '0;
      top_sw_q  <= 1'b0;
      win_rom_q <= 1'b0;
    end else begin
      if (bank_wr) bank_q[cpu_wr_addr[1:0]] <= cpu_wr_data[6:0];
      if (mode_wr) begin
        pmode_q   <= cpu_wr_data[1:0];
        top_sw_q  <= cpu_wr_data[2];
        win_rom_q <= cpu_wr_data[7];
      end
    end
  end

  function automatic logic [6:0] rev7(input logic [6:0] v);
    for (int i = 0; i < 7; i++) rev7[i] = v[6-i];
  endfunction

  logic [6:0] rv [4];
  always_comb
    for (int i = 0; i < 4; i++)
      rv[i] = (pmode_q == 2'd3) ? rev7(bank_q[i]) : bank_q[i];

  wire [1:0] slot  = cpu_rd_addr[14:13];
  wire       upper = cpu_rd_addr[15];
  wire       win   = cpu_rd_addr[15:13] == 3'b011;
  wire [6:0] top   = top_sw_q ? rv[3] : 7'h7F;

  logic [8:0] b8;
  always_comb begin
    if (!upper) begin
      case (pmode_q)
        2'd0:    b8 = {rv[3], 2'b11};
        2'd1:    b8 = {1'b0, rv[3], 1'b1};
        default: b8 = {2'b00, rv[3]};
      endcase
    end else begin
      case (pmode_q)
        2'd0:    b8 = {top, slot};
        2'd1:    b8 = {1'b0, slot[1] ? top : rv[1], slot[0]};
        default: b8 = {2'b00, (slot == 2'd3) ? top : rv[slot]};
      endcase
    end
  end

  assign prg_addr = {outer_bank, b8[INNER_W-1:0], cpu_rd_addr[12:0]};
  assign rom_en   = upper || (win && win_rom_q);
  assign wram_en  = win && !win_rom_q;

  wire unused_bits = ^{b8, cpu_wr_addr[10:2], cpu_wr_data[6:3]};

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int OUTER_W = 2,
  parameter int AW = 21
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr_en,
  input logic [15:0]        cpu_wr_addr,
  input logic [15:0]        cpu_rd_addr,
  input logic [OUTER_W-1:0] outer_bank,
  input logic [AW-1:0]      prg_addr,
  input logic               rom_en,
  input logic               wram_en
);

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_en && wram_en));

  assert_low_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_addr < 16'h6000) |-> (!rom_en && !wram_en));

  assert_offset_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (prg_addr[12:0] == cpu_rd_addr[12:0]));

  assert_outer_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (prg_addr[AW-1 -: OUTER_W] == outer_bank));

  assert_a11_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && cpu_wr_addr[11]) |=>
      (!($stable(cpu_rd_addr) && $stable(outer_bank)) ||
       ($stable(prg_addr) && $stable(rom_en) && $stable(wram_en))));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.OUTER_W(OUTER_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr),
  .cpu_rd_addr(cpu_rd_addr), .outer_bank(outer_bank), .prg_addr(prg_addr),
  .rom_en(rom_en), .wram_en(wram_en));

// File: tb/tb_prg_bank_mapper.sv
`timescale 1ns/1ps
module tb_prg_bank_mapper;
  localparam int AW = 21;
  localparam int NV = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr_en = 1'b0;
  logic [15:0] cpu_wr_addr = '0;
  logic [7:0]  cpu_wr_data = '0;
  logic [15:0] cpu_rd_addr = '0;
  logic [1:0]  outer_bank = 2'b10;
  logic [AW-1:0] prg_addr;
  logic rom_en, wram_en;
  int n_run = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  prg_bank_mapper dut (.clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data), .cpu_rd_addr(cpu_rd_addr),
    .outer_bank(outer_bank), .prg_addr(prg_addr), .rom_en(rom_en), .wram_en(wram_en));

  // {write, addr, data, bank, rom, wram}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0,16'h8123,8'h00,6'h3C,1'b1,1'b0}, // R11 R6 R7
    {1'b0,16'hFFFF,8'h00,6'h3F,1'b1,1'b0}, // R11 R7
    {1'b0,16'h6000,8'h00,6'h00,1'b0,1'b1}, // R11 R9
    {1'b0,16'h4020,8'h00,6'h00,1'b0,1'b0}, // R13
    {1'b1,16'h8000,8'h05,6'h00,1'b0,1'b0}, // R1
    {1'b1,16'h8001,8'h0A,6'h00,1'b0,1'b0},
    {1'b1,16'h8002,8'h13,6'h00,1'b0,1'b0},
    {1'b1,16'h8003,8'hA1,6'h00,1'b0,1'b0},
    {1'b1,16'hD000,8'h02,6'h00,1'b0,1'b0}, // R3
    {1'b0,16'h8000,8'h00,6'h05,1'b1,1'b0}, // R4
    {1'b0,16'hA456,8'h00,6'h0A,1'b1,1'b0}, // R4
    {1'b0,16'hC000,8'h00,6'h13,1'b1,1'b0}, // R4
    {1'b0,16'hE000,8'h00,6'h3F,1'b1,1'b0}, // R7
    {1'b1,16'hD000,8'h06,6'h00,1'b0,1'b0},
    {1'b0,16'hE789,8'h00,6'h21,1'b1,1'b0}, // R4 R7 R1
    {1'b1,16'hD000,8'h05,6'h00,1'b0,1'b0},
    {1'b0,16'h8000,8'h00,6'h14,1'b1,1'b0}, // R5
    {1'b0,16'hA000,8'h00,6'h15,1'b1,1'b0}, // R5
    {1'b0,16'hC000,8'h00,6'h02,1'b1,1'b0}, // R5 R10
    {1'b0,16'hE000,8'h00,6'h03,1'b1,1'b0}, // R5
    {1'b1,16'hD000,8'h01,6'h00,1'b0,1'b0},
    {1'b0,16'hC000,8'h00,6'h3E,1'b1,1'b0}, // R7
    {1'b1,16'hD000,8'h04,6'h00,1'b0,1'b0},
    {1'b0,16'h8000,8'h00,6'h04,1'b1,1'b0}, // R6
    {1'b0,16'hE000,8'h00,6'h07,1'b1,1'b0}, // R6
    {1'b1,16'hD000,8'h84,6'h00,1'b0,1'b0},
    {1'b0,16'h6000,8'h00,6'h07,1'b1,1'b0}, // R9
    {1'b1,16'hD000,8'h85,6'h00,1'b0,1'b0},
    {1'b0,16'h7FFF,8'h00,6'h03,1'b1,1'b0}, // R9
    {1'b1,16'hD000,8'h86,6'h00,1'b0,1'b0},
    {1'b0,16'h6000,8'h00,6'h21,1'b1,1'b0}, // R9
    {1'b1,16'hD000,8'h87,6'h00,1'b0,1'b0},
    {1'b0,16'h6000,8'h00,6'h02,1'b1,1'b0}, // R8
    {1'b0,16'h8000,8'h00,6'h10,1'b1,1'b0}, // R8
    {1'b1,16'h8800,8'h3F,6'h00,1'b0,1'b0}, // R2
    {1'b1,16'hD800,8'h00,6'h00,1'b0,1'b0}, // R2
    {1'b0,16'h8000,8'h00,6'h10,1'b1,1'b0}, // R2
    {1'b1,16'hD001,8'h00,6'h00,1'b0,1'b0}, // R3
    {1'b1,16'h87F1,8'h11,6'h00,1'b0,1'b0}, // R1
    {1'b0,16'hA000,8'h00,6'h04,1'b1,1'b0}  // R1 R3 R8
  };

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [15:0] a, input logic [5:0] bank,
                     input logic rom, input logic wram);
    logic [AW-1:0] exp;
    cpu_rd_addr = a;
    #1;
    exp = {outer_bank, bank, a[12:0]};
    n_run++;
    if (rom_en !== rom || wram_en !== wram || (rom && prg_addr !== exp)) begin
      n_fail++;
      $display("FAIL %s addr=%h: got addr=%h rom=%b wram=%b, exp addr=%h rom=%b wram=%b",
               req, a, prg_addr, rom_en, wram_en, exp, rom, wram);
    end
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) wr(VEC[i][31:16], VEC[i][15:8]);
      else begin
        @(negedge clk);
        chk("R4-table", VEC[i][31:16], VEC[i][7:2], VEC[i][1], VEC[i][0]);
      end
    end

    // R12: mapping changes in the cycle right after the write
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_addr = 16'h8000; cpu_wr_data = 8'h40;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    chk("R12", 16'h8000, 6'h01, 1'b1, 1'b0);

    // R10: outer bits follow the input
    outer_bank = 2'b01;
    chk("R10", 16'h8000, 6'h01, 1'b1, 1'b0);

    // R11: reset returns to 32 KiB fixed-last with WRAM window
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R11", 16'hA000, 6'h3D, 1'b1, 1'b0);
    chk("R11", 16'h7000, 6'h00, 1'b0, 1'b1);
    chk("R13", 16'h0000, 6'h00, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule